// File: doc/BRIEF.md
# Dual PS/2 Channel Register Front End

This block is the host-side register front end for two PS/2 channels: a keyboard channel (channel 0) and a mouse channel (channel 1). A single byte-wide register bus reaches both channels. `bus_sel` picks the channel, and address bits [3:2] pick a register inside that channel's window. Each window holds a fixed identity register, a data register, a control register and a status register. The identity register is read-only. The data register transmits on write and receives on read. The control register can be read and written. The status register is read-only. The two channel interrupt levels are ORed into one interrupt output, and every status register also shows that merged level.

Outside loopback, a byte written to the data register goes out to an external line serializer as a one-cycle strobe. A data read pops the external receive queue of that channel. In loopback mode the channel keeps the written byte locally instead. It raises its own interrupt and flags the receive side as non-empty. The next data read returns the byte and clears the interrupt and the flag. A diagnostic control bit lets software force the two line-shadow status bits through the direction control bits.

Reads are combinational. `bus_rdata` is valid in the same cycle as `bus_rd`. Any side effect of the read (queue pop, loopback flag clear) takes effect at the next rising clock edge.

Top module: `ps2_dual_regif`

## Requirements
- R1: Register decode uses only `bus_addr[3:2]`. The other address bits are ignored. Read offsets: 0 = identity, 1 = data, 2 = control, 3 = status. The identity register reads 0x00 for channel 0 and 0x01 for channel 1.
- R2: Writing offset 2 loads the control byte of the selected channel, and offset 2 reads it back. Synchronous reset clears both control bytes, both loopback buffers and both loopback flags. Control bit 1 is loopback, bit 5 is diagnostic, bit 6 is data direction and bit 7 is clock direction.
- R3: With loopback set, a data write does the following:
  - It stores the byte locally.
  - It sets the loopback flag of that channel, which is also that channel's interrupt.
  - It raises no transmit strobe.
- R4: With loopback set, a data read returns the stored byte and clears the loopback flag in the next cycle. It does not pop the external queue.
- R5: Status bit 6 (data shadow) and bit 7 (clock shadow) read 1 by default. When diagnostic is set, bit 6 reads 0 if data direction is 0, and bit 7 reads 0 if clock direction is 0.
- R6: Status bit 0 (receive not empty) follows the loopback flag when loopback is set. Otherwise it follows that channel's `rx_valid`.
- R7: `irq_out` is the OR of both channel interrupts. A channel interrupt is its `dev_irq` input ORed with its loopback flag. Status bit 4 shows `irq_out` in both windows.
- R8: Outside loopback, a data write raises `tx_valid` of that channel for exactly the next cycle, with the byte on its `tx_data` lane.
- R9: Outside loopback, a data read returns `rx_data` and pulses `rx_ready` in the same cycle when `rx_valid` is high. When `rx_valid` is low, the read returns 0x00 and does not pulse `rx_ready`.
- R10: Status bits 1, 2 and 3 show that channel's `tx_busy`, `tx_err` and `par_err` inputs. Status bit 5 reads 0.
- R11: A write to offset 0 or offset 3 changes no state and raises no strobe. `bus_rdata` is 0x00 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Channel select: 0 keyboard, 1 mouse |
| bus_addr | input | ADDR_W | Byte address within the channel window; only bits [3:2] decode |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle as `bus_rd` |
| tx_valid | output | 2 | Per-channel transmit strobe to the serializer |
| tx_data | output | 16 | Per-channel transmit byte; channel n in bits [8n+7:8n] |
| rx_valid | input | 2 | Per-channel receive queue not empty |
| rx_data | input | 16 | Per-channel head of receive queue |
| rx_ready | output | 2 | Per-channel pop strobe to the receive queue |
| dev_irq | input | 2 | Per-channel interrupt level from the device side |
| tx_busy | input | 2 | Per-channel serializer holding a byte |
| tx_err | input | 2 | Per-channel transmit error |
| par_err | input | 2 | Per-channel receive parity error |
| irq_out | output | 1 | Combined interrupt |

## Verification
The assertions check these relations on every cycle:
- A transmit strobe appears only one cycle after a data write to the same channel.
- A pop occurs only during a read while the queue holds data.
- Any device interrupt reaches `irq_out`.
- Every status read shows `irq_out` in bit 4.
- Every identity read matches the channel select.

The other behaviours live in state that can only be seen through reads, so only the bench's scenarios can show them. These are the loopback store and clear sequence, the shadow-bit truth table across the diagnostic and direction bits, the source of the receive-not-empty bit, and the absence of any effect from writes to offsets 0 and 3. The bench steps a behavioural model through each of these sequences and compares every output on every cycle.

// File: rtl/ps2ri_pkg.sv
package ps2ri_pkg;

    localparam int BYTE_W    = 8;
    localparam int NUM_CHANS = 2;

    // Register selector from address bits [3:2]; the order is the bus contract.
    typedef enum logic [1:0] {
        OFS_IDENT = 2'd0,   // read: identity, write: no effect
        OFS_DATA  = 2'd1,   // read: receive, write: transmit
        OFS_CTRL  = 2'd2,
        OFS_STAT  = 2'd3    // read only
    } reg_ofs_e;

    typedef struct packed {
        logic       clk_dir;
        logic       dat_dir;
        logic       diag;
        logic [2:0] spare;
        logic       loop;
        logic       enable;
    } ctrl_t;

    typedef struct packed {
        logic clk_shadow;
        logic dat_shadow;
        logic spare;
        logic merged_irq;
        logic par_err;
        logic tx_err;
        logic tx_busy;
        logic rx_nonempty;
    } stat_t;

    function automatic reg_ofs_e decode_ofs(input logic [1:0] word_sel);
        return reg_ofs_e'(word_sel);
    endfunction

endpackage

// File: rtl/ps2ri_status.sv
module ps2ri_status
    import ps2ri_pkg::*;
(
    input  logic  diag,
    input  logic  dat_dir,
    input  logic  clk_dir,
    input  logic  rx_nonempty,
    input  logic  tx_busy,
    input  logic  tx_err,
    input  logic  par_err,
    input  logic  merged_irq,
    output stat_t stat
);
    always_comb begin
        stat             = '0;
        stat.clk_shadow  = !(diag && !clk_dir);
        stat.dat_shadow  = !(diag && !dat_dir);
        stat.merged_irq  = merged_irq;
        stat.par_err     = par_err;
        stat.tx_err      = tx_err;
        stat.tx_busy     = tx_busy;
        stat.rx_nonempty = rx_nonempty;
    end
endmodule

// File: rtl/ps2ri_chan.sv
module ps2ri_chan
    import ps2ri_pkg::*;
#(
    parameter int CHAN_ID = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  reg_ofs_e          ofs,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              dev_irq,
    input  logic              tx_busy,
    input  logic              tx_err,
    input  logic              par_err,
    input  logic              merged_irq,
    output logic [BYTE_W-1:0] rdata,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    output logic              rx_ready,
    output logic              chan_irq
);
    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] lb_buf_q;
    logic              lb_full_q;
    logic              tx_valid_q;
    logic [BYTE_W-1:0] tx_data_q;
    stat_t             stat_w;

    logic wr_data, rd_data, wr_ctrl;
    assign wr_data = wr_en && (ofs == OFS_DATA);
    assign wr_ctrl = wr_en && (ofs == OFS_CTRL);
    assign rd_data = rd_en && (ofs == OFS_DATA);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            lb_buf_q   <= '0;
            lb_full_q  <= 1'b0;
            tx_valid_q <= 1'b0;
            tx_data_q  <= '0;
        end else begin
            tx_valid_q <= 1'b0;
            if (wr_ctrl) begin
                ctrl_q <= ctrl_t'(wdata);
            end
            if (wr_data) begin
                if (ctrl_q.loop) begin
                    lb_buf_q  <= wdata;
                    lb_full_q <= 1'b1;
                end else begin
                    tx_valid_q <= 1'b1;
                    tx_data_q  <= wdata;
                end
            end
            if (rd_data && ctrl_q.loop) begin
                lb_full_q <= 1'b0;
            end
        end
    end

    assign tx_valid = tx_valid_q;
    assign tx_data  = tx_data_q;
    assign rx_ready = rd_data && !ctrl_q.loop && rx_valid;
    assign chan_irq = dev_irq || lb_full_q;

    ps2ri_status u_stat (
        .diag        (ctrl_q.diag),
        .dat_dir     (ctrl_q.dat_dir),
        .clk_dir     (ctrl_q.clk_dir),
        .rx_nonempty (ctrl_q.loop ? lb_full_q : rx_valid),
        .tx_busy     (tx_busy),
        .tx_err      (tx_err),
        .par_err     (par_err),
        .merged_irq  (merged_irq),
        .stat        (stat_w)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (ofs)
                OFS_IDENT: rdata = BYTE_W'(CHAN_ID);
                OFS_DATA:  rdata = ctrl_q.loop ? lb_buf_q
                                 : (rx_valid ? rx_data : '0);
                OFS_CTRL:  rdata = ctrl_q;
                OFS_STAT:  rdata = stat_w;
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ps2_dual_regif.sv
module ps2_dual_regif
    import ps2ri_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int LANES_W = NUM_CHANS * BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_sel,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [BYTE_W-1:0]    bus_wdata,
    output logic [BYTE_W-1:0]    bus_rdata,
    output logic [NUM_CHANS-1:0] tx_valid,
    output logic [LANES_W-1:0]   tx_data,
    input  logic [NUM_CHANS-1:0] rx_valid,
    input  logic [LANES_W-1:0]   rx_data,
    output logic [NUM_CHANS-1:0] rx_ready,
    input  logic [NUM_CHANS-1:0] dev_irq,
    input  logic [NUM_CHANS-1:0] tx_busy,
    input  logic [NUM_CHANS-1:0] tx_err,
    input  logic [NUM_CHANS-1:0] par_err,
    output logic                 irq_out
);
    reg_ofs_e             ofs;
    logic [NUM_CHANS-1:0] chan_irq;
    logic [BYTE_W-1:0]    chan_rdata [NUM_CHANS];
    logic                 unused_addr_bits;

    assign ofs              = decode_ofs(bus_addr[3:2]);
    assign unused_addr_bits = ^{bus_addr[ADDR_W-1:4], bus_addr[1:0]};
    assign irq_out          = |chan_irq;

    for (genvar c = 0; c < NUM_CHANS; c++) begin : g_chan
        ps2ri_chan #(.CHAN_ID(c)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .wr_en      (bus_wr && (bus_sel == 1'(c))),
            .rd_en      (bus_rd && (bus_sel == 1'(c))),
            .ofs        (ofs),
            .wdata      (bus_wdata),
            .rx_valid   (rx_valid[c]),
            .rx_data    (rx_data[c*BYTE_W +: BYTE_W]),
            .dev_irq    (dev_irq[c]),
            .tx_busy    (tx_busy[c]),
            .tx_err     (tx_err[c]),
            .par_err    (par_err[c]),
            .merged_irq (irq_out),
            .rdata      (chan_rdata[c]),
            .tx_valid   (tx_valid[c]),
            .tx_data    (tx_data[c*BYTE_W +: BYTE_W]),
            .rx_ready   (rx_ready[c]),
            .chan_irq   (chan_irq[c])
        );
    end

    // Each channel drives zero unless selected, so an OR merges them.
    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CHANS; c++) begin
            bus_rdata = bus_rdata | chan_rdata[c];
        end
    end
endmodule

// File: rtl/ps2ri_checks.sv
module ps2ri_checks (
    input logic       clk,
    input logic       rst,
    input logic       bus_sel,
    input logic [1:0] bus_ofs,
    input logic       bus_wr,
    input logic       bus_rd,
    input logic [7:0] bus_rdata,
    input logic [1:0] tx_valid,
    input logic [1:0] rx_valid,
    input logic [1:0] rx_ready,
    input logic [1:0] dev_irq,
    input logic       irq_out
);
    assert_tx0_follows_write_R8: assert property (@(posedge clk) disable iff (rst)
        tx_valid[0] |-> $past(bus_wr && !bus_sel && bus_ofs == 2'd1));

    assert_tx1_follows_write_R8: assert property (@(posedge clk) disable iff (rst)
        tx_valid[1] |-> $past(bus_wr && bus_sel && bus_ofs == 2'd1));

    assert_pop0_needs_data_R9: assert property (@(posedge clk) disable iff (rst)
        rx_ready[0] |-> (rx_valid[0] && bus_rd && !bus_sel && bus_ofs == 2'd1));

    assert_pop1_needs_data_R9: assert property (@(posedge clk) disable iff (rst)
        rx_ready[1] |-> (rx_valid[1] && bus_rd && bus_sel && bus_ofs == 2'd1));

    assert_dev_irq_reaches_out_R7: assert property (@(posedge clk) disable iff (rst)
        (dev_irq != 2'b00) |-> irq_out);

    assert_status_shows_irq_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_ofs == 2'd3) |-> (bus_rdata[4] == irq_out));

    assert_ident_value_R1: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_ofs == 2'd0) |-> (bus_rdata == {7'b0, bus_sel}));

    assert_idle_rdata_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == 8'h00));
endmodule

bind ps2_dual_regif ps2ri_checks u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_ofs   (bus_addr[3:2]),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .tx_valid  (tx_valid),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .dev_irq   (dev_irq),
    .irq_out   (irq_out)
);

// File: tb/ps2_dual_regif_tb.sv
module ps2_dual_regif_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  wdata = 8'h00;
    logic [1:0]  rxv = 2'b00;
    logic [15:0] rxd = 16'h0000;
    logic [1:0]  dirq = 2'b00;
    logic [1:0]  tbusy = 2'b00;
    logic [1:0]  terr = 2'b00;
    logic [1:0]  perr = 2'b00;
    logic [7:0]  bus_rdata;
    logic [1:0]  tx_valid;
    logic [15:0] tx_data;
    logic [1:0]  rx_ready;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [7:0] last_rd;

    // behavioural model state
    bit [7:0] m_ctrl [2];
    bit [7:0] m_lb   [2];
    bit       m_lbf  [2];
    bit       m_txv  [2];
    bit [7:0] m_txd  [2];

    always #5 clk = ~clk;

    ps2_dual_regif u_dut (
        .clk(clk), .rst(rst), .bus_sel(sel), .bus_addr(addr), .bus_wr(wr),
        .bus_rd(rd), .bus_wdata(wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .rx_valid(rxv), .rx_data(rxd),
        .rx_ready(rx_ready), .dev_irq(dirq), .tx_busy(tbusy), .tx_err(terr),
        .par_err(perr), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic bit m_irq();
        return dirq[0] | dirq[1] | m_lbf[0] | m_lbf[1];
    endfunction

    function automatic logic [7:0] m_rdata();
        int  p = sel;
        bit  lp = m_ctrl[p][1];
        bit  dg = m_ctrl[p][5];
        logic [7:0] st;
        if (!rd) return 8'h00;
        case (addr[3:2])
            2'd0: return 8'(p);
            2'd1: return lp ? m_lb[p] : (rxv[p] ? rxd[p*8 +: 8] : 8'h00);
            2'd2: return m_ctrl[p];
            default: begin
                st = 8'h00;
                st[7] = !(dg && !m_ctrl[p][7]);
                st[6] = !(dg && !m_ctrl[p][6]);
                st[4] = m_irq();
                st[3] = perr[p];
                st[2] = terr[p];
                st[1] = tbusy[p];
                st[0] = lp ? m_lbf[p] : rxv[p];
                return st;
            end
        endcase
    endfunction

    // One clock: compare all outputs mid-cycle, then advance the model at the edge.
    task automatic cyc(input string tag);
        logic [1:0] exp_pop;
        #2;
        last_rd = bus_rdata;
        chk(tag, "rdata", {8'h00, bus_rdata}, {8'h00, m_rdata()});
        chk(tag, "irq_out", {15'h0, irq_out}, {15'h0, m_irq()});
        for (int p = 0; p < 2; p++)
            exp_pop[p] = rd && (int'(sel) == p) && addr[3:2] == 2'd1
                         && !m_ctrl[p][1] && rxv[p];
        chk(tag, "rx_ready", {14'h0, rx_ready}, {14'h0, exp_pop});
        chk(tag, "tx_valid", {14'h0, tx_valid}, {14'h0, m_txv[1], m_txv[0]});
        for (int p = 0; p < 2; p++)
            if (m_txv[p]) chk(tag, "tx_data", {8'h00, tx_data[p*8 +: 8]}, {8'h00, m_txd[p]});
        @(posedge clk);
        for (int p = 0; p < 2; p++) begin
            bit lp = m_ctrl[p][1];
            bit here = (int'(sel) == p);
            if (rst) begin
                m_ctrl[p] = 0; m_lb[p] = 0; m_lbf[p] = 0; m_txv[p] = 0;
            end else begin
                m_txv[p] = 0;
                if (wr && here && addr[3:2] == 2'd2) m_ctrl[p] = wdata;
                if (wr && here && addr[3:2] == 2'd1) begin
                    if (lp) begin m_lb[p] = wdata; m_lbf[p] = 1; end
                    else begin m_txv[p] = 1; m_txd[p] = wdata; end
                end
                if (rd && here && addr[3:2] == 2'd1 && lp) m_lbf[p] = 0;
            end
        end
        @(negedge clk);
    endtask

    task automatic op(input logic s, input logic [7:0] a, input logic w,
                      input logic r, input logic [7:0] d, input string tag);
        sel = s; addr = a; wr = w; rd = r; wdata = d;
        cyc(tag);
        wr = 0; rd = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        for (int p = 0; p < 2; p++) begin
            m_ctrl[p] = 0; m_lb[p] = 0; m_lbf[p] = 0; m_txv[p] = 0; m_txd[p] = 0;
        end
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // reset state (R2, R5)
        op(0, 8'h08, 0, 1, 0, "R2");
        chk("R2", "ctrl after reset", {8'h0, last_rd}, 16'h0000);
        op(1, 8'h0C, 0, 1, 0, "R5");
        chk("R5", "status after reset", {8'h0, last_rd}, 16'h00C0);
        cyc("R11");

        // identity and decode (R1)
        op(0, 8'h00, 0, 1, 0, "R1");
        chk("R1", "kbd ident", {8'h0, last_rd}, 16'h0000);
        op(1, 8'h31, 0, 1, 0, "R1");
        chk("R1", "mouse ident aliased", {8'h0, last_rd}, 16'h0001);
        op(0, 8'hFA, 1, 0, 8'h81, "R1");
        op(0, 8'h0B, 0, 1, 0, "R1");
        chk("R1", "ctrl via alias", {8'h0, last_rd}, 16'h0081);

        // shadow bits (R5)
        op(0, 8'h08, 1, 0, 8'h20, "R5");
        op(0, 8'h0C, 0, 1, 0, "R5");
        chk("R5", "diag both low", {8'h0, last_rd & 8'hC0}, 16'h0000);
        op(0, 8'h08, 1, 0, 8'h60, "R5");
        op(0, 8'h0C, 0, 1, 0, "R5");
        chk("R5", "diag data dir", {8'h0, last_rd & 8'hC0}, 16'h0040);
        op(0, 8'h08, 1, 0, 8'hA0, "R5");
        op(0, 8'h0C, 0, 1, 0, "R5");
        chk("R5", "diag clk dir", {8'h0, last_rd & 8'hC0}, 16'h0080);
        op(0, 8'h08, 1, 0, 8'hC0, "R5");
        op(0, 8'h0C, 0, 1, 0, "R5");
        chk("R5", "dirs without diag", {8'h0, last_rd & 8'hC0}, 16'h00C0);
        op(0, 8'h08, 1, 0, 8'h00, "R2");

        // transmit strobe (R8)
        op(1, 8'h04, 1, 0, 8'h3C, "R8");
        cyc("R8");
        op(0, 8'h04, 1, 0, 8'hE7, "R8");
        cyc("R8");

        // receive path (R6, R9)
        rxv = 2'b01; rxd = 16'h995A;
        op(0, 8'h0C, 0, 1, 0, "R6");
        chk("R6", "rbne from queue", {15'h0, last_rd[0]}, 16'h0001);
        op(0, 8'h04, 0, 1, 0, "R9");
        chk("R9", "rx byte", {8'h0, last_rd}, 16'h005A);
        op(1, 8'h04, 0, 1, 0, "R9");
        chk("R9", "empty read", {8'h0, last_rd}, 16'h0000);
        rxv = 2'b00;

        // status inputs (R10)
        tbusy = 2'b10; terr = 2'b10; perr = 2'b01;
        op(1, 8'h0C, 0, 1, 0, "R10");
        chk("R10", "status err bits", {8'h0, last_rd & 8'h2E}, 16'h0006);
        op(0, 8'h0C, 0, 1, 0, "R10");
        tbusy = 0; terr = 0; perr = 0;

        // loopback (R3, R4, R6, R7)
        op(1, 8'h08, 1, 0, 8'h03, "R3");
        rxv = 2'b10; rxd = 16'h1100;
        op(1, 8'h04, 1, 0, 8'h77, "R3");
        cyc("R3");
        op(0, 8'h0C, 0, 1, 0, "R7");
        chk("R7", "merged irq in kbd window", {15'h0, last_rd[4]}, 16'h0001);
        op(1, 8'h04, 0, 1, 0, "R4");
        chk("R4", "loop byte", {8'h0, last_rd}, 16'h0077);
        op(1, 8'h0C, 0, 1, 0, "R6");
        chk("R6", "rbne from loop flag", {15'h0, last_rd[0]}, 16'h0000);
        rxv = 2'b00;

        // device interrupt (R7)
        dirq = 2'b01;
        op(1, 8'h0C, 0, 1, 0, "R7");
        dirq = 2'b00;
        cyc("R7");

        // ignored writes (R11)
        op(0, 8'h00, 1, 0, 8'hFF, "R11");
        op(0, 8'h0C, 1, 0, 8'hFF, "R11");
        op(1, 8'h00, 1, 0, 8'hFF, "R11");
        op(0, 8'h08, 0, 1, 0, "R11");
        chk("R11", "ctrl unchanged", {8'h0, last_rd}, 16'h0000);
        op(1, 8'h08, 0, 1, 0, "R11");
        chk("R11", "ctrl unchanged", {8'h0, last_rd}, 16'h0003);

        // mid-run reset clears loopback state (R2)
        op(1, 8'h04, 1, 0, 8'h42, "R3");
        rst = 1;
        cyc("R2");
        rst = 0;
        op(1, 8'h08, 0, 1, 0, "R2");
        chk("R2", "ctrl cleared", {8'h0, last_rd}, 16'h0000);
        chk("R2", "irq cleared", {15'h0, irq_out}, 16'h0000);

        done = 1;
        finish_run();
    end
endmodule